// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register front end of one eight-input priority interrupt controller. It accepts byte writes on a two-address port and sorts them into four kinds of traffic: an initialization sequence of up to four words, mask loads, read and poll set-up commands, and end-of-interrupt or priority-rotation commands. It holds the mask, vector base, mode flags and rotating priority base, and it drives one-cycle clear strobes toward the request and in-service vectors, which live in a separate resolver.

Reads are served in the same cycle from the decoder's own mask or from the resolver's request and in-service vectors. When poll mode is armed, the next read returns the index of the winning input instead and clears that input. A separate trigger-mode register holds one bit per input and keeps only the bits that a fixed, per-instance writable mask allows.

Top module: `irqc_cmd_decoder`

## Requirements
- R1: After synchronous reset, mask_out, vec_base, prio_base, nest_special, auto_eoi, rotate_auto, smask_mode, init_active and level_sel are all zero, and rdata is zero whenever rd_en is low.
- R2: A write to reg_sel=0 with wdata bit 4 set starts initialization. In that same cycle isr_clr and irr_clr are 8'hFF. From the next cycle, mask, prio_base, vec_base, the read select, poll, special mask, auto-EOI, rotate mode and nested mode are zero and init_active is high. wdata bit 0 of that write records whether a mode word follows.
- R3: During initialization, writes to reg_sel=1 leave mask_out unchanged. The first one loads vec_base from wdata[7:3]. The second is consumed. A third is accepted only if the mode word was requested: it sets nest_special from bit 4 and auto_eoi from bit 1. init_active falls after the last word.
- R4: A write to reg_sel=1 while init_active is low loads mask_out with wdata.
- R5: A write to reg_sel=0 with bit 3 set and bit 4 clear arms poll mode if bit 2 is set; if bit 1 is set, bit 0 picks the read select (1 = in-service, 0 = request); if bit 6 is set, smask_mode takes bit 5.
- R6: A write to reg_sel=0 with bits 4 and 3 clear decodes wdata[7:5] as a command. Codes 0 and 4 set rotate_auto to bit 7. Code 2 changes no output.
- R7: Codes 1 and 5 clear, through isr_clr in the same cycle, the set svc_vec bit of highest priority. Priority rank is (index - prio_base) mod 8, and lower ranks are higher. Code 5 then sets prio_base to that index + 1 mod 8. With svc_vec zero, nothing changes.
- R8: Code 3 pulses isr_clr for index wdata[2:0]. Code 6 sets prio_base to wdata[2:0]+1 mod 8. Code 7 does both.
- R9: A read with poll disarmed returns mask_out for reg_sel=1. For reg_sel=0 it returns svc_vec if the read select is 1 and req_vec if it is 0.
- R10: A read with poll armed returns the index of the winner and pulses that bit on both irr_clr and isr_clr. The winner is the highest-priority set bit of req_vec & ~mask_out, and it must rank strictly above every set bit of svc_vec. On the master, while nest_special is set, svc_vec bit 2 is left out of that comparison. With no winner, the read returns 7 and clears nothing. Poll disarms after the read.
- R11: A trigger write stores wdata & WMASK into level_sel, where WMASK is 8'hF8 on the master and 8'hDE otherwise. Initialization does not alter level_sel.
- R12: When a read and a write fall in the same cycle, the read sees the state before the write, the clear strobes of both are ORed, and a poll-arming write keeps poll armed across a poll read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the two-address port |
| rd_en | input | 1 | Read strobe for the two-address port |
| reg_sel | input | 1 | Register select (0 = command, 1 = data) |
| wdata | input | 8 | Write data, shared with the trigger write |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| req_vec | input | 8 | Request vector from the resolver |
| svc_vec | input | 8 | In-service vector from the resolver |
| rdata | output | 8 | Read data, valid in the cycle of rd_en |
| mask_out | output | 8 | Interrupt mask |
| vec_base | output | 5 | Vector base, bits 7..3 of the vector |
| nest_special | output | 1 | Special nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rotate_auto | output | 1 | Rotate on automatic end of interrupt |
| smask_mode | output | 1 | Special mask mode |
| prio_base | output | 3 | Index of the highest-priority input |
| isr_clr | output | 8 | One-cycle in-service clear strobes |
| irr_clr | output | 8 | One-cycle request clear strobes |
| init_active | output | 1 | Initialization in progress; interrupt output is held low |
| level_sel | output | 8 | Trigger-mode register |

## Verification
Two functions can fall in the same cycle: a poll read, which clears the winner and disarms poll, and a command write, which may clear a second in-service bit or re-arm poll. The bench drives both strobes together, once with a specific end-of-interrupt on another input and once with a poll-arming command. It checks that the strobes hold the union of both clears, that the read data reflects the state before the write, and that the next read is still served in poll mode. A per-cycle behavioural model checks the same union during a long stretch of mixed random traffic.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the interrupt command decoder.
// Assumes a byte-wide port and eight inputs, so indices are three bits wide.
package irqc_pkg;
    localparam int LINES       = 8;
    localparam int IDX_W       = $clog2(LINES);
    localparam int BASE_W      = 8 - IDX_W;
    localparam int CASCADE_PIN = 2;

    typedef enum logic [1:0] {
        INIT_IDLE = 2'd0,
        INIT_BASE = 2'd1,
        INIT_SKIP = 2'd2,
        INIT_MODE = 2'd3
    } init_st_t;
endpackage

// File: rtl/irqc_prio_find.sv
// Rotating priority finder: returns the set bit of highest priority, where
// priority rank is (index - base) mod N and rank 0 wins.
// Assumes N is a power of two so index arithmetic wraps by truncation.
module irqc_prio_find #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] base,
    output logic         found,
    output logic [W-1:0] idx,
    output logic [W-1:0] rank
);
    logic [W-1:0] pos;

    // Scan from lowest priority upward so the last hit is the best one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = base + W'(k);
            if (vec[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
        rank = idx - base;
    end
endmodule

// File: rtl/irqc_init_seq.sv
// Initialization word sequencer. Tracks which data-port write is expected
// after a start command and holds the vector base and mode flags.
// Assumes the start command and a data write never coincide (different address).
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              data_wr,
    input  logic [7:0]        wdata,
    output logic              init_active,
    output logic              mask_wr,
    output logic [BASE_W-1:0] vec_base,
    output logic              nest_special,
    output logic              auto_eoi
);
    init_st_t st;
    logic     mode_wanted;

    // Sequence state and the words it captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= INIT_IDLE;
            mode_wanted  <= 1'b0;
            vec_base     <= '0;
            nest_special <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (start_wr) begin
            st           <= INIT_BASE;
            mode_wanted  <= wdata[0];
            vec_base     <= '0;
            nest_special <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (data_wr) begin
            case (st)
                INIT_BASE: begin
                    vec_base <= wdata[7:IDX_W];
                    st       <= INIT_SKIP;
                end
                INIT_SKIP: st <= mode_wanted ? INIT_MODE : INIT_IDLE;
                INIT_MODE: begin
                    nest_special <= wdata[4];
                    auto_eoi     <= wdata[1];
                    st           <= INIT_IDLE;
                end
                default: st <= INIT_IDLE;
            endcase
        end
    end

    // Data writes outside the sequence go to the mask.
    assign mask_wr     = data_wr && (st == INIT_IDLE);
    assign init_active = (st != INIT_IDLE);
endmodule

// File: rtl/irqc_trig_reg.sv
// Trigger-mode register: keeps only the bits that this instance allows.
// Assumes the writable mask is fixed by the master/slave role.
module irqc_trig_reg #(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] level_sel
);
    logic [7:0] wmask;

    // Pick the writable mask for the role.
    generate
        if (IS_MASTER) begin : g_master
            assign wmask = 8'hF8;
        end else begin : g_slave
            assign wmask = 8'hDE;
        end
    endgenerate

    // Store the filtered write.
    always_ff @(posedge clk) begin
        if (!rst_n)  level_sel <= '0;
        else if (wr) level_sel <= wdata & wmask;
    end
endmodule

// File: rtl/irqc_cmd_decoder.sv
// Command decoder of one eight-input interrupt controller: decodes the
// two-address byte port, holds mask and priority base, serves reads and
// poll reads, and strobes clears toward an external resolver.
// Assumes req_vec/svc_vec come from that resolver and that it applies the
// clear strobes on the edge after they are asserted.
module irqc_cmd_decoder
    import irqc_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [7:0]        wdata,
    input  logic              trig_wr_en,
    input  logic [LINES-1:0]  req_vec,
    input  logic [LINES-1:0]  svc_vec,
    output logic [7:0]        rdata,
    output logic [LINES-1:0]  mask_out,
    output logic [BASE_W-1:0] vec_base,
    output logic              nest_special,
    output logic              auto_eoi,
    output logic              rotate_auto,
    output logic              smask_mode,
    output logic [IDX_W-1:0]  prio_base,
    output logic [LINES-1:0]  isr_clr,
    output logic [LINES-1:0]  irr_clr,
    output logic              init_active,
    output logic [LINES-1:0]  level_sel
);
    logic             start_wr, sel_wr, op_wr, mask_wr, poll_rd;
    logic [2:0]       code;
    logic             rd_svc, poll_armed;
    logic             eoi_found, req_found, cmp_found, poll_win;
    logic [IDX_W-1:0] eoi_idx, eoi_rank, req_idx, req_rank, cmp_idx, cmp_rank;
    logic [LINES-1:0] cmp_vec;

    assign start_wr = wr_en && !reg_sel && wdata[4];
    assign sel_wr   = wr_en && !reg_sel && !wdata[4] && wdata[3];
    assign op_wr    = wr_en && !reg_sel && !wdata[4] && !wdata[3];
    assign code     = wdata[7:5];
    assign poll_rd  = rd_en && poll_armed;

    irqc_init_seq i_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr),
        .data_wr(wr_en && reg_sel), .wdata(wdata),
        .init_active(init_active), .mask_wr(mask_wr), .vec_base(vec_base),
        .nest_special(nest_special), .auto_eoi(auto_eoi)
    );

    irqc_trig_reg #(.IS_MASTER(IS_MASTER)) i_trig (
        .clk(clk), .rst_n(rst_n), .wr(trig_wr_en), .wdata(wdata),
        .level_sel(level_sel)
    );

    // Highest-priority in-service input for non-specific end of interrupt.
    irqc_prio_find #(.N(LINES)) i_eoi_find (
        .vec(svc_vec), .base(prio_base),
        .found(eoi_found), .idx(eoi_idx), .rank(eoi_rank)
    );

    // Best unmasked request for poll reads.
    irqc_prio_find #(.N(LINES)) i_req_find (
        .vec(req_vec & ~mask_out), .base(prio_base),
        .found(req_found), .idx(req_idx), .rank(req_rank)
    );

    // In-service level the request must beat; cascade input left out in nested mode.
    generate
        if (IS_MASTER) begin : g_cmp_master
            assign cmp_vec = nest_special ?
                (svc_vec & ~(LINES'(1) << CASCADE_PIN)) : svc_vec;
        end else begin : g_cmp_slave
            assign cmp_vec = svc_vec;
        end
    endgenerate

    irqc_prio_find #(.N(LINES)) i_cmp_find (
        .vec(cmp_vec), .base(prio_base),
        .found(cmp_found), .idx(cmp_idx), .rank(cmp_rank)
    );

    assign poll_win = req_found && (!cmp_found || (req_rank < cmp_rank));

    // Decoder-held state: mask, priority base, read/poll/mode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_out    <= '0;
            prio_base   <= '0;
            rd_svc      <= 1'b0;
            poll_armed  <= 1'b0;
            smask_mode  <= 1'b0;
            rotate_auto <= 1'b0;
        end else begin
            if (poll_rd) poll_armed <= 1'b0;
            if (start_wr) begin
                mask_out    <= '0;
                prio_base   <= '0;
                rd_svc      <= 1'b0;
                poll_armed  <= 1'b0;
                smask_mode  <= 1'b0;
                rotate_auto <= 1'b0;
            end else if (mask_wr) begin
                mask_out <= wdata;
            end else if (sel_wr) begin
                if (wdata[2]) poll_armed <= 1'b1;
                if (wdata[1]) rd_svc     <= wdata[0];
                if (wdata[6]) smask_mode <= wdata[5];
            end else if (op_wr) begin
                case (code)
                    3'd0, 3'd4: rotate_auto <= code[2];
                    3'd5: if (eoi_found) prio_base <= eoi_idx + 1'b1;
                    3'd6: prio_base <= wdata[IDX_W-1:0] + 1'b1;
                    3'd7: prio_base <= wdata[IDX_W-1:0] + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Clear strobes from commands and poll reads, merged.
    always_comb begin
        isr_clr = '0;
        irr_clr = '0;
        if (start_wr) begin
            isr_clr = '1;
            irr_clr = '1;
        end else if (op_wr) begin
            case (code)
                3'd1, 3'd5: if (eoi_found) isr_clr[eoi_idx] = 1'b1;
                3'd3, 3'd7: isr_clr[wdata[IDX_W-1:0]] = 1'b1;
                default: ;
            endcase
        end
        if (poll_rd && poll_win) begin
            isr_clr[req_idx] = 1'b1;
            irr_clr[req_idx] = 1'b1;
        end
    end

    // Read data, valid in the cycle of rd_en.
    always_comb begin
        if (!rd_en)          rdata = '0;
        else if (poll_armed) rdata = poll_win ? 8'(req_idx) : 8'd7;
        else if (reg_sel)    rdata = mask_out;
        else                 rdata = rd_svc ? svc_vec : req_vec;
    end
endmodule

// File: rtl/irqc_cmd_checker.sv
// Property checker for the command decoder, attached by bind.
// Assumes only the top-level ports are observed.
module irqc_cmd_checker #(
    parameter bit IS_MASTER = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       reg_sel,
    input logic [7:0] wdata,
    input logic       trig_wr_en,
    input logic [7:0] mask_out,
    input logic [2:0] prio_base,
    input logic [7:0] irr_clr,
    input logic       init_active,
    input logic [7:0] level_sel
);
    localparam logic [7:0] WMASK = IS_MASTER ? 8'hF8 : 8'hDE;

    // R2
    init_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wdata[4]) |=> (init_active && mask_out == 8'h00 && prio_base == 3'd0));

    // R3
    init_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_active && wr_en && reg_sel) |=> $stable(mask_out));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_active && wr_en && reg_sel) |=> (mask_out == $past(wdata)));

    // R8
    base_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wdata[7:3] == 5'b11000) |=> (prio_base == 3'($past(wdata[2:0]) + 3'd1)));

    // R10
    poll_single_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !reg_sel && wdata[4]) |-> $onehot0(irr_clr));

    // R11
    trig_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_en |=> (level_sel == ($past(wdata) & WMASK)));
endmodule

bind irqc_cmd_decoder irqc_cmd_checker #(.IS_MASTER(IS_MASTER)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wdata(wdata), .trig_wr_en(trig_wr_en), .mask_out(mask_out),
    .prio_base(prio_base), .irr_clr(irr_clr), .init_active(init_active),
    .level_sel(level_sel)
);

// File: tb/test_irqc_cmd_decoder.sv
`timescale 1ns/1ps
module test_irqc_cmd_decoder;
    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, reg_sel = 0, trig_wr_en = 0;
    logic [7:0] wdata = 0, req_vec = 0, svc_vec = 0;
    logic [7:0] rdata, mask_out, isr_clr, irr_clr, level_sel;
    logic [4:0] vec_base;
    logic [2:0] prio_base;
    logic nest_special, auto_eoi, rotate_auto, smask_mode, init_active;

    always #10 clk = ~clk;

    irqc_cmd_decoder #(.IS_MASTER(1'b1)) i_irqc_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wdata(wdata), .trig_wr_en(trig_wr_en), .req_vec(req_vec), .svc_vec(svc_vec),
        .rdata(rdata), .mask_out(mask_out), .vec_base(vec_base),
        .nest_special(nest_special), .auto_eoi(auto_eoi), .rotate_auto(rotate_auto),
        .smask_mode(smask_mode), .prio_base(prio_base), .isr_clr(isr_clr),
        .irr_clr(irr_clr), .init_active(init_active), .level_sel(level_sel)
    );

    int checks = 0, errors = 0;
    string tag = "R1";

    // Reference model state
    int m_imr = 0, m_base = 0, m_nest = 0, m_aeoi = 0, m_rot = 0, m_smask = 0;
    int m_pb = 0, m_rsel = 0, m_poll = 0, m_need4 = 0, m_st = 0, m_trig = 0;

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int rank_of(int vec, int pb);
        for (int k = 0; k < 8; k++)
            if ((vec >> ((pb + k) % 8)) & 1) return k;
        return 8;
    endfunction

    // One cycle: drive, compare against the model, then advance the model.
    task automatic cyc(bit wr, bit rd, bit sel, int d, bit tw, int irr, int isr);
        int e_isr, e_irr, e_rd, c, r, rq, sv, w;
        int n_imr, n_base, n_nest, n_aeoi, n_rot, n_smask, n_pb, n_rsel, n_poll, n_need4, n_st, n_trig;
        bit start;
        wr_en = wr; rd_en = rd; reg_sel = sel; wdata = 8'(d); trig_wr_en = tw;
        req_vec = 8'(irr); svc_vec = 8'(isr);
        #2;
        e_isr = 0; e_irr = 0; e_rd = 0;
        start = wr && !sel && d[4];
        c = (d >> 5) & 7;
        r = rank_of(isr, m_pb);
        if (start) begin e_isr = 255; e_irr = 255; end
        else if (wr && !sel && !d[3]) begin
            if ((c == 1 || c == 5) && r < 8) e_isr |= 1 << ((r + m_pb) % 8);
            if (c == 3 || c == 7) e_isr |= 1 << (d & 7);
        end
        if (rd && m_poll) begin
            rq = rank_of(irr & ~m_imr & 255, m_pb);
            sv = rank_of(isr & ~(m_nest ? 4 : 0), m_pb);
            if (rq < 8 && rq < sv) begin
                w = (rq + m_pb) % 8; e_rd = w; e_isr |= 1 << w; e_irr |= 1 << w;
            end else e_rd = 7;
        end else if (rd) e_rd = sel ? m_imr : (m_rsel ? isr : irr);
        check("rdata", rdata, e_rd);
        check("isr_clr", isr_clr, e_isr);
        check("irr_clr", irr_clr, e_irr);
        check("mask_out", mask_out, m_imr);
        check("vec_base", vec_base, m_base);
        check("nest_special", nest_special, m_nest);
        check("auto_eoi", auto_eoi, m_aeoi);
        check("rotate_auto", rotate_auto, m_rot);
        check("smask_mode", smask_mode, m_smask);
        check("prio_base", prio_base, m_pb);
        check("init_active", init_active, m_st != 0);
        check("level_sel", level_sel, m_trig);
        n_imr = m_imr; n_base = m_base; n_nest = m_nest; n_aeoi = m_aeoi; n_rot = m_rot;
        n_smask = m_smask; n_pb = m_pb; n_rsel = m_rsel; n_poll = m_poll; n_need4 = m_need4;
        n_st = m_st; n_trig = m_trig;
        if (rd && m_poll) n_poll = 0;
        if (start) begin
            n_imr = 0; n_base = 0; n_nest = 0; n_aeoi = 0; n_rot = 0; n_smask = 0;
            n_pb = 0; n_rsel = 0; n_poll = 0; n_st = 1; n_need4 = d & 1;
        end else if (wr && sel) begin
            case (m_st)
                0: n_imr = d;
                1: begin n_base = d >> 3; n_st = 2; end
                2: n_st = m_need4 ? 3 : 0;
                default: begin n_nest = (d >> 4) & 1; n_aeoi = (d >> 1) & 1; n_st = 0; end
            endcase
        end else if (wr && !sel && d[3]) begin
            if (d[2]) n_poll = 1;
            if (d[1]) n_rsel = d & 1;
            if (d[6]) n_smask = (d >> 5) & 1;
        end else if (wr && !sel) begin
            case (c)
                0, 4: n_rot = c >> 2;
                5: if (r < 8) n_pb = ((r + m_pb) % 8 + 1) % 8;
                6, 7: n_pb = ((d & 7) + 1) % 8;
                default: ;
            endcase
        end
        if (tw) n_trig = d & 8'hF8;
        @(posedge clk);
        m_imr = n_imr; m_base = n_base; m_nest = n_nest; m_aeoi = n_aeoi; m_rot = n_rot;
        m_smask = n_smask; m_pb = n_pb; m_rsel = n_rsel; m_poll = n_poll; m_need4 = n_need4;
        m_st = n_st; m_trig = n_trig;
        @(negedge clk);
    endtask

    task automatic wr0(int d);            cyc(1, 0, 0, d, 0, 0, 0); endtask
    task automatic wr1(int d);            cyc(1, 0, 1, d, 0, 0, 0); endtask
    task automatic rd(bit s, int irr, int isr); cyc(0, 1, s, 0, 0, irr, isr); endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        tag = "R1";
        cyc(0, 0, 0, 0, 0, 8'hFF, 8'hFF);
        check("R1 mask after reset", mask_out, 0);
        // R2, R3: init with mode word
        tag = "R2"; wr0(8'h11);
        tag = "R3"; wr1(8'h48); wr1(8'h04); wr1(8'h12);
        check("R3 base", vec_base, 9);
        // R3: init without mode word, then next data write is a mask
        tag = "R3"; wr0(8'h10); wr1(8'h20); wr1(8'h00); wr1(8'hAA);
        check("R3 mask after short init", mask_out, 8'hAA);
        // R4, R9
        tag = "R4"; wr1(8'h5A);
        tag = "R9"; rd(1, 0, 0); rd(0, 8'h33, 8'h0C); wr0(8'h0B); rd(0, 8'h33, 8'h0C); wr0(8'h0A);
        // R5
        tag = "R5"; wr0(8'h68); wr0(8'h48); wr0(8'h6C);
        // R10: poll winner, blocked, masked
        tag = "R10"; wr1(8'h10); rd(0, 8'h30, 8'h00);
        wr0(8'h0C); rd(1, 8'h30, 8'h01);
        wr0(8'h0C); rd(0, 8'h10, 8'h00);
        rd(0, 8'h33, 8'h00);
        // R10: nested mode on the master ignores cascade in-service
        tag = "R10"; wr0(8'h11); wr1(8'h00); wr1(8'h00); wr1(8'h10);
        wr0(8'h0C); rd(0, 8'h08, 8'h04);
        // R6
        tag = "R6"; wr0(8'h80); wr0(8'h40); wr0(8'h00);
        // R7
        tag = "R7"; cyc(1, 0, 0, 8'h20, 0, 0, 8'h0A); cyc(1, 0, 0, 8'hA0, 0, 0, 8'h0A);
        cyc(1, 0, 0, 8'h20, 0, 0, 8'h0A); cyc(1, 0, 0, 8'hA0, 0, 0, 8'h00);
        // R8
        tag = "R8"; wr0(8'h65); wr0(8'hC3); wr0(8'hE6);
        // R11
        tag = "R11"; cyc(0, 0, 0, 8'hFF, 1, 0, 0); wr0(8'h10);
        check("R11 level after init", level_sel, 8'hF8);
        wr1(0); wr1(0);
        // R12: poll read with a specific EOI and with a re-arm in the same cycle
        tag = "R12"; wr0(8'h0C); cyc(1, 1, 0, 8'h63, 0, 8'h02, 8'h00);
        wr0(8'h0C); cyc(1, 1, 0, 8'h0C, 0, 8'h04, 8'h00); rd(1, 8'h04, 8'h00);
        // Mixed random traffic against the model
        tag = "R12";
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 256),
                1'($urandom % 4 == 0), int'($urandom % 256), int'($urandom % 256));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule